// File: doc/BRIEF.md
# Mode-selectable five-decade BCD counter

This block is a chain of decimal counting stages (units, tens, hundreds, thousands, ten-thousands) that advances once per rising edge of a slow count input. The count input is not used as a clock. It passes through a short synchronizer on the system clock, and its rising edge becomes a single-cycle tick. Every stage and every output is therefore synchronous to `clk`. All five BCD digits are visible at once on one packed bus. A carry-out flag lets several such counters be chained.

A two-bit mode input sets how the units stage feeds the tens stage. In the plain decimal mode the tens stage advances when units wraps from nine to zero. Two rounding modes move that carry to the units stage's 4→5 or 7→8 step, which gives a four-digit counter with a divide-by-ten and round-off front end. In those two modes the units digit is flagged as not for display. A test mode feeds the tick straight into several stages, so long counts can be reached in few input pulses.

A synchronous, active-high reset clears every stage and drives the carry-out high. The carry-out stays high until the first count after the reset is released.

Top module: `decade_chain_counter`

## Requirements
- R1: While `rst` is high at a rising `clk` edge, all digits become 0 and `carry_out` becomes 1 at that edge. Reset takes priority over any count activity in the same cycle.
- R2: Each low-to-high change of `count_in` advances the chain exactly once. The input must be seen low at one `clk` edge and high at the next (edge E). The digits change at the second `clk` edge after E. Holding `count_in` high gives no further advances, and with no advance the digits hold.
- R3: Digit k occupies `digits[4k+3:4k]` (units at bits 3:0). Each digit is BCD, never above 9. On every advance the units digit steps 0,1,…,9,0 in every mode, and a stage at 9 that is advanced returns to 0.
- R4: Mode 2'b00 (decimal): tens advances when units steps 9→0. Each higher stage advances when the stage below it steps 9→0 on the same advance, forming a five-digit decimal counter.
- R5: Mode 2'b01 (round at five): tens advances only when units steps 4→5. Higher stages cascade as in R4.
- R6: Mode 2'b11 (round at eight): tens advances only when units steps 7→8. Units wrapping 9→0 carries nothing.
- R7: Mode 2'b10 (test): units, tens and thousands advance on every tick. Hundreds advances when tens steps 9→0, and ten-thousands advances when thousands steps 9→0.
- R8: On each advance, `carry_out` becomes 1 if the ten-thousands stage stepped 9→0 on that advance, and 0 otherwise. It then holds until the next advance.
- R9: `first_valid` is 0 one `clk` cycle after `mode[0]` is 1 (modes 01 and 11), and 1 one cycle after `mode[0]` is 0. The units stage keeps counting internally in all modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high master reset |
| count_in | input | 1 | Count input, sampled and edge-detected on `clk` |
| mode | input | 2 | Carry routing select: 00 decimal, 01 round at five, 11 round at eight, 10 test |
| digits | output | 20 | Five BCD digits, units in bits 3:0 |
| carry_out | output | 1 | High from a top-stage wrap until the next advance; high during reset |
| first_valid | output | 1 | Units digit is meant for display (low in the rounding modes) |

## Verification
The assertions check on every cycle that each digit stays within BCD range and that a stage at nine returns to zero when advanced. They also check that the digits hold when no tick occurs, that a tick never lasts two cycles, that reset clears the chain and raises the carry, and how the carry flag and the display flag follow their causes. Only the bench's scenarios can show the mode-dependent tap points (4→5, 7→8, 9→0), the stages driven directly in test mode, the two-edge input latency, and a full all-nines rollover. For these the bench runs a behavioural model with integer digits next to the design and compares the two on every clock.

// File: rtl/dcc_pkg.sv
package dcc_pkg;

  typedef logic [3:0] bcd_t;

  typedef enum logic [1:0] {
    MODE_DECIMAL = 2'b00,
    MODE_ROUND5  = 2'b01,
    MODE_TEST    = 2'b10,
    MODE_ROUND8  = 2'b11
  } mode_e;

  localparam bcd_t BCD_MAX    = 4'd9;
  localparam bcd_t TAP_ROUND5 = 4'd4;
  localparam bcd_t TAP_ROUND8 = 4'd7;

  function automatic bcd_t bcd_inc(input bcd_t v);
    return (v >= BCD_MAX) ? 4'd0 : 4'(v + 4'd1);
  endfunction

endpackage

// File: rtl/dcc_edge_detect.sv
module dcc_edge_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  localparam int W = SYNC_STAGES + 1;

  logic [W-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[W-2:0], din};
  end

  assign rise = sh[W-2] & ~sh[W-1];

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise); // R2

endmodule

// File: rtl/dcc_decade.sv
module dcc_decade
  import dcc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en,
  output bcd_t value,
  output logic wrap
);

  always_ff @(posedge clk) begin
    if (rst)     value <= '0;
    else if (en) value <= bcd_inc(value);
  end

  assign wrap = en && (value == BCD_MAX);

  AST_BCD_RANGE: assert property (@(posedge clk) disable iff (rst)
    value <= BCD_MAX); // R3
  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
    wrap |=> value == 4'd0); // R3
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(value)); // R2

endmodule

// File: rtl/dcc_first_carry.sv
module dcc_first_carry
  import dcc_pkg::*;
(
  input  logic       tick,
  input  logic [1:0] mode,
  input  bcd_t       unit_val,
  output logic       carry
);

  always_comb begin
    unique case (mode_e'(mode))
      MODE_DECIMAL: carry = tick && (unit_val == BCD_MAX);
      MODE_ROUND5:  carry = tick && (unit_val == TAP_ROUND5);
      MODE_ROUND8:  carry = tick && (unit_val == TAP_ROUND8);
      MODE_TEST:    carry = tick;
      default:      carry = 1'b0;
    endcase
  end

  always_comb begin
    if (!tick) AST_NO_CARRY_IDLE: assert (!carry); // R4
  end

endmodule

// File: rtl/decade_chain_counter.sv
module decade_chain_counter
  import dcc_pkg::*;
#(
  parameter int              NDIG        = 5,
  parameter int              SYNC_STAGES = 2,
  parameter logic [NDIG-1:0] TEST_DIRECT = 5'b01011
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              count_in,
  input  logic [1:0]        mode,
  output logic [4*NDIG-1:0] digits,
  output logic              carry_out,
  output logic              first_valid
);

  logic tick;
  logic first_carry;
  logic is_test;
  logic last_wrap;

  assign is_test = (mode_e'(mode) == MODE_TEST);

  dcc_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk  (clk),
    .rst  (rst),
    .din  (count_in),
    .rise (tick)
  );

  for (genvar k = 0; k < NDIG; k++) begin : g_stage
    logic en_k;
    logic wrap_k;
    bcd_t val_k;

    if (k == 0) begin : g_units
      assign en_k = tick;
    end else if (k == 1) begin : g_second
      assign en_k = (is_test && TEST_DIRECT[k]) ? tick : first_carry;
    end else begin : g_upper
      assign en_k = (is_test && TEST_DIRECT[k]) ? tick : g_stage[k-1].wrap_k;
    end

    dcc_decade u_dec (
      .clk   (clk),
      .rst   (rst),
      .en    (en_k),
      .value (val_k),
      .wrap  (wrap_k)
    );

    assign digits[4*k +: 4] = val_k;
  end

  dcc_first_carry u_route (
    .tick     (tick),
    .mode     (mode),
    .unit_val (g_stage[0].val_k),
    .carry    (first_carry)
  );

  assign last_wrap = g_stage[NDIG-1].wrap_k;

  always_ff @(posedge clk) begin
    if (rst)       carry_out <= 1'b1;
    else if (tick) carry_out <= last_wrap;
  end

  always_ff @(posedge clk) begin
    if (rst) first_valid <= ~mode[0];
    else     first_valid <= ~mode[0];
  end

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (digits == '0) && carry_out); // R1
  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(digits)); // R2
  AST_CARRY_SET: assert property (@(posedge clk) disable iff (rst)
    (tick && last_wrap) |=> carry_out); // R8
  AST_CARRY_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (tick && !last_wrap) |=> !carry_out); // R8
  AST_CARRY_HOLD: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(carry_out)); // R8
  AST_FLAG_MASKED: assert property (@(posedge clk) disable iff (rst)
    mode[0] |=> !first_valid); // R9
  AST_FLAG_SHOWN: assert property (@(posedge clk) disable iff (rst)
    !mode[0] |=> first_valid); // R9

endmodule

// File: tb/tb_decade_chain_counter.sv
module tb_decade_chain_counter;
  localparam int NDIG = 5;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              count_in = 1'b0;
  logic [1:0]        mode = 2'b00;
  logic [4*NDIG-1:0] digits;
  logic              carry_out;
  logic              first_valid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int md [NDIG];
  bit mcy = 1'b1;
  bit mfv = 1'b1;
  bit h0 = 1'b0, h1 = 1'b0, h2 = 1'b0;

  always #10 clk = ~clk;

  decade_chain_counter dut (
    .clk(clk), .rst(rst), .count_in(count_in), .mode(mode),
    .digits(digits), .carry_out(carry_out), .first_valid(first_valid)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // Behavioural reference: integer digits updated per clock
  always @(posedge clk) begin : model
    int  od [NDIG];
    bit  e  [NDIG];
    bit  tk;
    bit  c1;
    if (rst) begin
      for (int i = 0; i < NDIG; i++) md[i] = 0;
      mcy = 1'b1;
      h0 = 1'b0; h1 = 1'b0; h2 = 1'b0;
    end else begin
      tk = h1 && !h2;
      h2 = h1; h1 = h0; h0 = count_in;
      if (tk) begin
        for (int i = 0; i < NDIG; i++) od[i] = md[i];
        case (mode)
          2'b00:   c1 = (od[0] == 9);
          2'b01:   c1 = (od[0] == 4);
          2'b11:   c1 = (od[0] == 7);
          default: c1 = 1'b1;
        endcase
        e[0] = 1'b1;
        for (int i = 1; i < NDIG; i++) begin
          if (mode == 2'b10 && (i == 1 || i == 3)) e[i] = 1'b1;
          else if (i == 1)                        e[i] = c1;
          else                                    e[i] = e[i-1] && (od[i-1] == 9);
        end
        for (int i = 0; i < NDIG; i++) md[i] = e[i] ? (od[i] + 1) % 10 : od[i];
        mcy = e[NDIG-1] && (od[NDIG-1] == 9);
      end
    end
    mfv = !mode[0];
  end

  // Compare with the model on every clock
  always @(negedge clk) begin : compare
    logic [4*NDIG-1:0] exp_d;
    string tag;
    if (!done) begin
      for (int i = 0; i < NDIG; i++) exp_d[4*i +: 4] = 4'(md[i]);
      if (rst) tag = "R1";
      else case (mode)
        2'b00:   tag = "R4";
        2'b01:   tag = "R5";
        2'b11:   tag = "R6";
        default: tag = "R7";
      endcase
      chk(digits == exp_d, tag, "digits vs model", 32'(digits), 32'(exp_d));
      chk(carry_out == mcy, "R8", "carry_out vs model", 32'(carry_out), 32'(mcy));
      chk(first_valid == mfv, "R9", "first_valid vs model", 32'(first_valid), 32'(mfv));
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int n);
    repeat (n) begin
      count_in = 1'b1; cyc(3);
      count_in = 1'b0; cyc(2);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; cyc(3); rst = 1'b0;
  endtask

  initial begin
    cyc(3);
    chk(digits == '0, "R1", "digits in reset", 32'(digits), 0);
    chk(carry_out == 1'b1, "R1", "carry_out in reset", 32'(carry_out), 1);
    chk(first_valid == 1'b1, "R9", "flag in mode 00", 32'(first_valid), 1);
    count_in = 1'b1; cyc(4);
    chk(digits == '0, "R1", "count ignored under reset", 32'(digits), 0);
    count_in = 1'b0; rst = 1'b0; cyc(2);

    count_in = 1'b1; cyc(1);
    chk(digits[3:0] == 4'd0, "R2", "units one edge after rise", 32'(digits[3:0]), 0);
    cyc(1);
    chk(digits[3:0] == 4'd0, "R2", "units two edges after rise", 32'(digits[3:0]), 0);
    cyc(1);
    chk(digits[3:0] == 4'd1, "R2", "units three edges after rise", 32'(digits[3:0]), 1);
    cyc(8);
    chk(digits[3:0] == 4'd1, "R2", "held high counts once", 32'(digits[3:0]), 1);
    chk(carry_out == 1'b0, "R8", "carry cleared by first count", 32'(carry_out), 0);
    count_in = 1'b0; cyc(2);

    pulse(24);
    chk(digits == 20'h00025, "R4", "decimal count 25", 32'(digits), 32'h25);

    do_reset(); mode = 2'b01; cyc(1);
    pulse(12);
    chk(digits == 20'h00012, "R5", "round-at-five after 12", 32'(digits), 32'h12);
    chk(first_valid == 1'b0, "R9", "flag masked in mode 01", 32'(first_valid), 0);

    do_reset(); mode = 2'b11; cyc(1);
    pulse(19);
    chk(digits == 20'h00029, "R6", "round-at-eight after 19", 32'(digits), 32'h29);
    chk(first_valid == 1'b0, "R9", "flag masked in mode 11", 32'(first_valid), 0);
    pulse(1);
    chk(digits == 20'h00020, "R3", "units wraps without carry in mode 11", 32'(digits), 32'h20);

    do_reset(); mode = 2'b10; cyc(1);
    pulse(99);
    chk(digits == 20'h99999, "R7", "test mode after 99", 32'(digits), 32'h99999);
    chk(first_valid == 1'b1, "R9", "flag shown in mode 10", 32'(first_valid), 1);

    mode = 2'b00;
    pulse(1);
    chk(digits == '0, "R4", "all-nines rollover", 32'(digits), 0);
    chk(carry_out == 1'b1, "R8", "carry after top wrap", 32'(carry_out), 1);
    pulse(1);
    chk(digits == 20'h00001, "R3", "count after rollover", 32'(digits), 1);
    chk(carry_out == 1'b0, "R8", "carry cleared next count", 32'(carry_out), 0);

    cyc(2);
    finish_up();
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_up();
    end
  end

endmodule